// File: doc/BRIEF.md
# Triple Channel Prescaled Timer Counter

This block holds three independent up-counting timer channels behind one word-addressed register port. Each channel has its own clock control, counter control, read-only count value, interval limit, status and enable registers. A channel's copy of each register lies 4 bytes above the previous channel's copy. A channel advances either on every clock or once every 2^(N+1) clocks when its prescaler is on. It can be halted and resumed without losing its count, restarted from zero with a self-clearing control bit, and run free (wrapping at all-ones) or in interval mode. In interval mode it wraps after the programmed limit and flags an event.

Software sees a pending event in the channel's status register. Reading that register returns the flags and clears them in the same access. Each channel drives one interrupt line: its status flag gated by its enable bit. The count width is a parameter (16 or 32 bits), and the register read data is registered.

Top module: `tri_timer`

## Requirements
- R1: Byte addresses for channel c (0..2) are clock control 0x00+4c, counter control 0x0C+4c, count value 0x18+4c, interval 0x24+4c, status 0x54+4c and enable 0x60+4c. An address with bits 1:0 nonzero, or any other address, reads as zero, and a write to it changes nothing.
- R2: Clock control bit 0 turns the prescaler on, and bits 4:1 hold N. With bit 0 set, the count advances once every 2^(N+1) clocks. With bit 0 clear, it advances every clock. Clock control reads back the 6 bits last written.
- R3: Clock control bit 5 is a source flag. It reads back as written and has no effect on counting.
- R4: While counter control bit 0 is 1 the count holds. Clearing the bit resumes counting from the held value.
- R5: A counter control write with bit 4 set zeroes the count and the prescaler in that cycle. Bit 4 always reads back 0. Bits 0, 1, 2, 3 and 5 read back as written, and bit 5 has no effect.
- R6: In free-running mode (counter control bit 1 clear), the count wraps from all-ones to zero.
- R7: In interval mode (counter control bit 1 set), on an advance where the count equals the interval register, the count returns to zero and status bit 0 is set.
- R8: A status read returns the flags held before the access and clears them. If a new event arrives in the same cycle as the read, the event wins and the flag stays set.
- R9: A channel's irq bit equals status bit 0 AND enable bit 0 in every cycle, so writing zero to the enable register masks the line.
- R10: After reset, counter control reads 0x21 (channel halted, interval-mode bit clear, bit 5 set), every other register reads 0, and irq is 0.
- R11: The count value register is read-only: writes to it are ignored.
- R12: Read data appears on reg_rdata after the clock edge at which reg_re is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
A channel's interval event and a software read of its status register can land in the same clock edge. The bench provokes this by restarting a channel with a known interval and counting idle cycles so that the status read is sampled at exactly the edge where the count wraps. The read is judged correct if it returns the old, empty flag. The event is judged to have survived if the irq line rises after that edge, and a second read must return the set flag and drop the line.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 6;
  localparam int CH_W   = 2;

  // word indices (byte address / 4) of channel 0 copies
  localparam int W_CLK = 0;
  localparam int W_CNT = 3;
  localparam int W_VAL = 6;
  localparam int W_IVL = 9;
  localparam int W_STS = 21;
  localparam int W_IEN = 24;

  // clock control bits
  localparam int CC_PRE_EN = 0;
  // counter control bits
  localparam int KC_OFF     = 0;
  localparam int KC_IVL     = 1;
  localparam int KC_RESTART = 4;

  localparam logic [CTRL_W-1:0] CNT_CTRL_INIT = 6'h21;
  localparam logic [CTRL_W-1:0] CNT_CTRL_KEEP = 6'h2F;

  typedef enum logic [2:0] {
    RK_NONE, RK_CLK, RK_CNT, RK_VAL, RK_IVL, RK_STS, RK_IEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [CH_W-1:0]  ch;
  } reg_sel_t;

  function automatic reg_sel_t decode_word(input logic [5:0] w, input int nch);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.ch   = '0;
    for (int c = 0; c < nch; c++) begin
      if (w == 6'(W_CLK + c)) begin s.kind = RK_CLK; s.ch = CH_W'(c); end
      if (w == 6'(W_CNT + c)) begin s.kind = RK_CNT; s.ch = CH_W'(c); end
      if (w == 6'(W_VAL + c)) begin s.kind = RK_VAL; s.ch = CH_W'(c); end
      if (w == 6'(W_IVL + c)) begin s.kind = RK_IVL; s.ch = CH_W'(c); end
      if (w == 6'(W_STS + c)) begin s.kind = RK_STS; s.ch = CH_W'(c); end
      if (w == 6'(W_IEN + c)) begin s.kind = RK_IEN; s.ch = CH_W'(c); end
    end
    return s;
  endfunction
endpackage

// File: rtl/ttc_prescale.sv
module ttc_prescale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             pre_en_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 ** SEL_W;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] lim;
  logic             at_lim;

  // limit = 2^(N+1) - 1
  assign lim    = ~({DIV_W{1'b1}} << (int'(pre_sel_i) + 1));
  assign at_lim = (pre_q == lim);
  assign tick_o = run_i && (!pre_en_i || at_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
    end else if (run_i && pre_en_i) begin
      pre_q <= at_lim ? '0 : pre_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && pre_en_i && !restart_i) |=> (!tick_o || !pre_en_i)); // R2
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_clk_i,
  input  logic              wr_cnt_i,
  input  logic              wr_ivl_i,
  input  logic              wr_ien_i,
  input  logic              rd_sts_i,
  output logic [CTRL_W-1:0] clk_ctrl_o,
  output logic [CTRL_W-1:0] cnt_ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  ivl_o,
  output logic              sts_o,
  output logic              ien_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] clk_q, cnt_q;
  logic [CNT_W-1:0]  count_q, ivl_q;
  logic              st_q, ien_q, irq_q;
  logic              restart, tick, hit, st_d, ien_d;
  logic              unused_wd;

  assign unused_wd = ^wdata_i;
  assign restart   = wr_cnt_i && wdata_i[KC_RESTART];

  ttc_prescale #(.SEL_W(4)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .run_i     (!cnt_q[KC_OFF]),
    .restart_i (restart),
    .pre_en_i  (clk_q[CC_PRE_EN]),
    .pre_sel_i (clk_q[4:1]),
    .tick_o    (tick)
  );

  assign hit   = tick && cnt_q[KC_IVL] && (count_q == ivl_q);
  // a fresh event outranks the clear-on-read
  assign st_d  = (hit && !restart) ? 1'b1 : (rd_sts_i ? 1'b0 : st_q);
  assign ien_d = wr_ien_i ? wdata_i[0] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= '0;
      cnt_q   <= CNT_CTRL_INIT;
      count_q <= '0;
      ivl_q   <= '0;
      st_q    <= 1'b0;
      ien_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_clk_i) clk_q <= wdata_i[CTRL_W-1:0];
      if (wr_cnt_i) cnt_q <= wdata_i[CTRL_W-1:0] & CNT_CTRL_KEEP;
      if (wr_ivl_i) ivl_q <= wdata_i[CNT_W-1:0];
      if (restart)   count_q <= '0;
      else if (hit)  count_q <= '0;
      else if (tick) count_q <= count_q + 1'b1;
      st_q  <= st_d;
      ien_q <= ien_d;
      irq_q <= st_d && ien_d;
    end
  end

  assign clk_ctrl_o = clk_q;
  assign cnt_ctrl_o = cnt_q;
  assign count_o    = count_q;
  assign ivl_o      = ivl_q;
  assign sts_o      = st_q;
  assign ien_o      = ien_q;
  assign irq_o      = irq_q;

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (cnt_q[KC_OFF] && !restart) |=> (count_q == $past(count_q))); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count_q == '0)); // R5
  AST_IVL_SET: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart) |=> (st_q && count_q == '0)); // R7
  AST_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_sts_i && !hit) |=> !st_q); // R8
  AST_IRQ_EQ: assert property (@(posedge clk) disable iff (rst)
    irq_q == (st_q && ien_q)); // R9
endmodule

// File: rtl/ttc_regif.sv
module ttc_regif
  import ttc_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic                         re_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NCH-1:0][CTRL_W-1:0]   clk_ctrl_i,
  input  logic [NCH-1:0][CTRL_W-1:0]   cnt_ctrl_i,
  input  logic [NCH-1:0][CNT_W-1:0]    count_i,
  input  logic [NCH-1:0][CNT_W-1:0]    ivl_i,
  input  logic [NCH-1:0]               sts_i,
  input  logic [NCH-1:0]               ien_i,
  output logic [NCH-1:0]               wr_clk_o,
  output logic [NCH-1:0]               wr_cnt_o,
  output logic [NCH-1:0]               wr_ivl_o,
  output logic [NCH-1:0]               wr_ien_o,
  output logic [NCH-1:0]               rd_sts_o,
  output logic [DATA_W-1:0]            rdata_o
);
  reg_sel_t          sel;
  logic              hi_zero, hit;
  logic [DATA_W-1:0] rdata_q;

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hi_zero = ~|addr_i[ADDR_W-1:8];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel = decode_word(addr_i[7:2], NCH);
  assign hit = hi_zero && (addr_i[1:0] == 2'b00) && (sel.kind != RK_NONE);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_strobe
      logic mine;
      assign mine        = hit && (sel.ch == CH_W'(c));
      assign wr_clk_o[c] = we_i && mine && (sel.kind == RK_CLK);
      assign wr_cnt_o[c] = we_i && mine && (sel.kind == RK_CNT);
      assign wr_ivl_o[c] = we_i && mine && (sel.kind == RK_IVL);
      assign wr_ien_o[c] = we_i && mine && (sel.kind == RK_IEN);
      assign rd_sts_o[c] = re_i && mine && (sel.kind == RK_STS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re_i) begin
      if (!hit) begin
        rdata_q <= '0;
      end else begin
        case (sel.kind)
          RK_CLK:  rdata_q <= DATA_W'(clk_ctrl_i[sel.ch]);
          RK_CNT:  rdata_q <= DATA_W'(cnt_ctrl_i[sel.ch]);
          RK_VAL:  rdata_q <= DATA_W'(count_i[sel.ch]);
          RK_IVL:  rdata_q <= DATA_W'(ivl_i[sel.ch]);
          RK_STS:  rdata_q <= DATA_W'(sts_i[sel.ch]);
          RK_IEN:  rdata_q <= DATA_W'(ien_i[sel.ch]);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_clk_o, wr_cnt_o, wr_ivl_o, wr_ien_o})); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> $stable(rdata_o)); // R12
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import ttc_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0][CTRL_W-1:0] clk_ctrl, cnt_ctrl;
  logic [NCH-1:0][CNT_W-1:0]  count, ivl;
  logic [NCH-1:0]             sts, ien;
  logic [NCH-1:0]             wr_clk, wr_cnt, wr_ivl, wr_ien, rd_sts;

  ttc_regif #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .we_i       (reg_we),
    .re_i       (reg_re),
    .addr_i     (reg_addr),
    .clk_ctrl_i (clk_ctrl),
    .cnt_ctrl_i (cnt_ctrl),
    .count_i    (count),
    .ivl_i      (ivl),
    .sts_i      (sts),
    .ien_i      (ien),
    .wr_clk_o   (wr_clk),
    .wr_cnt_o   (wr_cnt),
    .wr_ivl_o   (wr_ivl),
    .wr_ien_o   (wr_ien),
    .rd_sts_o   (rd_sts),
    .rdata_o    (reg_rdata)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ttc_channel #(.CNT_W(CNT_W)) u_ch (
        .clk        (clk),
        .rst        (rst),
        .wdata_i    (reg_wdata),
        .wr_clk_i   (wr_clk[c]),
        .wr_cnt_i   (wr_cnt[c]),
        .wr_ivl_i   (wr_ivl[c]),
        .wr_ien_i   (wr_ien[c]),
        .rd_sts_i   (rd_sts[c]),
        .clk_ctrl_o (clk_ctrl[c]),
        .cnt_ctrl_o (cnt_ctrl[c]),
        .count_o    (count[c]),
        .ivl_o      (ivl[c]),
        .sts_o      (sts[c]),
        .ien_o      (ien[c]),
        .irq_o      (irq[c])
      );
    end
  endgenerate

  AST_RESET_IRQ: assert property (@(posedge clk)
    rst |=> (irq == '0)); // R10
endmodule

// File: tb/tri_timer_test.sv
`timescale 1ns/1ps
module tri_timer_test;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int A_CLK = 'h00, A_CNT = 'h0C, A_VAL = 'h18;
  localparam int A_IVL = 'h24, A_STS = 'h54, A_IEN = 'h60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tri_timer #(.NCH(NCH), .CNT_W(CW), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] ad(input int base, input int ch);
    return 8'(base + 4 * ch);
  endfunction

  function automatic logic [31:0] exp_cnt(input int m, input int p, input bit imode, input int ivl);
    int k;
    k = m / p;
    if (imode) return 32'(k % (ivl + 1));
    return 32'(k % (1 << CW));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, prev;
    void'($urandom(32'd20250611));
    idle(3);
    rst = 1'b0;
    idle(1);

    // R10 reset values
    for (int c = 0; c < NCH; c++) begin
      rd(ad(A_CLK, c), v); chk("R10 clk ctrl", v, 0);
      rd(ad(A_CNT, c), v); chk("R10 cnt ctrl", v, 32'h21);
      rd(ad(A_VAL, c), v); chk("R10 value", v, 0);
      rd(ad(A_IVL, c), v); chk("R10 interval", v, 0);
      rd(ad(A_STS, c), v); chk("R10 status", v, 0);
      rd(ad(A_IEN, c), v); chk("R10 enable", v, 0);
    end
    chk("R10 irq", 32'(irq), 0);

    // R1 decode: unmapped and misaligned
    wr(8'h30, 32'hFF); rd(8'h30, v); chk("R1 unmapped", v, 0);
    wr(8'h01, 32'h3F); rd(8'h00, v); chk("R1 misaligned write", v, 0);
    rd(8'h01, v); chk("R1 misaligned read", v, 0);
    wr(ad(A_CLK, 1), 32'h1A);
    rd(ad(A_CLK, 0), v); chk("R1 ch0 untouched", v, 0);
    rd(ad(A_CLK, 2), v); chk("R1 ch2 untouched", v, 0);
    rd(ad(A_CLK, 1), v); chk("R2 clk readback", v, 32'h1A);

    // R12 read data registered and held
    rd(ad(A_CNT, 0), prev);
    reg_re = 1'b1; reg_addr = ad(A_CLK, 1);
    #1 chk("R12 before edge", reg_rdata, prev);
    @(negedge clk); reg_re = 1'b0;
    chk("R12 after edge", reg_rdata, 32'h1A);
    idle(2); chk("R12 hold", reg_rdata, 32'h1A);

    // R3 source flag, no effect on counting
    wr(ad(A_CLK, 0), 32'h20);
    rd(ad(A_CLK, 0), v); chk("R3 flag readback", v, 32'h20);
    wr(ad(A_CNT, 0), 32'h10); idle(10);
    rd(ad(A_VAL, 0), v); chk("R3 counts every clock", v, 10);

    // R5 self-clearing restart bit
    wr(ad(A_CNT, 0), 32'h33);
    rd(ad(A_CNT, 0), v); chk("R5 bit4 reads zero", v, 32'h23);
    rd(ad(A_VAL, 0), v); chk("R5 count zeroed", v, 0);

    // R11 read-only value
    wr(ad(A_VAL, 0), 32'h1234);
    rd(ad(A_VAL, 0), v); chk("R11 write ignored", v, 0);

    // R4 hold and resume
    wr(ad(A_CNT, 0), 32'h10); idle(7);
    rd(ad(A_VAL, 0), v); chk("R4 running", v, 7);
    wr(ad(A_CNT, 0), 32'h01);   // read edge and this edge both advance: 9
    idle(5); rd(ad(A_VAL, 0), v); chk("R4 held", v, 9);
    idle(5); rd(ad(A_VAL, 0), v); chk("R4 still held", v, 9);
    wr(ad(A_CNT, 0), 32'h00); idle(4);
    rd(ad(A_VAL, 0), v); chk("R4 resumed from held", v, 13);

    // R2 prescale N=1 -> divide by 4
    wr(ad(A_CLK, 1), 32'h03); wr(ad(A_CNT, 1), 32'h10); idle(11);
    rd(ad(A_VAL, 1), v); chk("R2 divide by 4", v, exp_cnt(11, 4, 1'b0, 0));
    wr(ad(A_CNT, 1), 32'h01);

    // R6 free-running wrap
    wr(ad(A_CNT, 2), 32'h10); idle(65535);
    rd(ad(A_VAL, 2), v); chk("R6 all ones", v, 32'hFFFF);
    rd(ad(A_VAL, 2), v); chk("R6 wrapped", v, 0);
    wr(ad(A_CNT, 2), 32'h01);

    // R7 interval wrap and status, R9 masked
    wr(ad(A_CLK, 1), 32'h00); wr(ad(A_IVL, 1), 5); wr(ad(A_IEN, 1), 0);
    wr(ad(A_CNT, 1), 32'h12); idle(6);
    rd(ad(A_VAL, 1), v); chk("R7 interval wrap", v, 0);
    chk("R9 masked irq", 32'(irq[1]), 0);
    rd(ad(A_STS, 1), v); chk("R7 status set", v, 1);
    rd(ad(A_STS, 1), v); chk("R8 cleared by read", v, 0);
    wr(ad(A_CNT, 1), 32'h03);

    // R8 collision: event and status read at the same edge
    wr(ad(A_CLK, 0), 0); wr(ad(A_IVL, 0), 20); wr(ad(A_IEN, 0), 1);
    rd(ad(A_STS, 0), v);
    wr(ad(A_CNT, 0), 32'h12); idle(20);
    rd(ad(A_STS, 0), v); chk("R8 collision read old", v, 0);
    chk("R8 event survives (irq)", 32'(irq[0]), 1);
    rd(ad(A_STS, 0), v); chk("R8 flag after collision", v, 1);
    chk("R9 irq drops after clear", 32'(irq[0]), 0);
    wr(ad(A_CNT, 0), 32'h01);

    // R9 enable gating
    wr(ad(A_CLK, 2), 0); wr(ad(A_IVL, 2), 3); wr(ad(A_IEN, 2), 0);
    wr(ad(A_CNT, 2), 32'h12); idle(10);
    wr(ad(A_CNT, 2), 32'h03);
    chk("R9 disabled irq", 32'(irq[2]), 0);
    wr(ad(A_IEN, 2), 1); chk("R9 enabled irq", 32'(irq[2]), 1);
    wr(ad(A_IEN, 2), 0); chk("R9 write zero masks", 32'(irq[2]), 0);
    rd(ad(A_STS, 2), v); chk("R9 status kept", v, 1);

    // random mix: R2 R6 R7
    for (int i = 0; i < 30; i++) begin
      int ch, n, m, ivl, p;
      bit pe, im;
      ch  = int'($urandom % 3);
      n   = int'($urandom % 3);
      pe  = 1'($urandom % 2);
      im  = 1'($urandom % 2);
      ivl = int'($urandom % 12);
      m   = int'($urandom % 60);
      p   = pe ? (1 << (n + 1)) : 1;
      wr(ad(A_CLK, ch), 32'((n << 1) | int'(pe)));
      wr(ad(A_IVL, ch), 32'(ivl));
      wr(ad(A_CNT, ch), im ? 32'h12 : 32'h10);
      idle(m);
      rd(ad(A_VAL, ch), v);
      chk(im ? "R7 random interval" : "R2 random prescale", v, exp_cnt(m, p, im, ivl));
      wr(ad(A_CNT, ch), 32'h01);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule